// File: doc/BRIEF.md
# FIFO Read Port Output Control

This block is the output stage on the read side of a synchronous FIFO. It sits between the FIFO storage, which presents the word at the head of the queue together with an empty indication, and the external read bus. It decides in which cycles the head word is taken out of storage (a pop), when the registered output word changes, and when the output bus is to be driven. Actual three-state pads are modelled by a separate drive-enable output, `dout_drive`.

The active-low chip select reaches the bus drive one read clock later. It does not act on the movement of data inside the FIFO. While the FIFO is in reset, only the active-low output enable controls the drive. In first-word-fall-through mode the block loads the head word into its output register as soon as one is available, whatever the state of chip select, and keeps that word until it is read. A read is refused in the first cycle in which chip select is active. A read enable asserted in that cycle is reported as a protocol error. A retransmit request is passed on only while chip select is active.

Top module: `rdport_out_ctrl`

## Requirements
- R1: `dout_drive` follows chip select with one clock of delay. A low `csel_n` sampled at a rising edge drives the bus from that edge on, as long as `oe_n` is low. A high `csel_n` sampled at a rising edge releases the bus from that edge on. A change of `csel_n` between edges does not alter `dout_drive`.
- R2: While `rst_busy` is high, `dout_drive` equals the inverse of `oe_n` at once, whatever the value of `csel_n`. `dout` is cleared to zero, `out_valid` is 0 and `pop` is 0.
- R3: If `oe_n` is low when `rst_busy` falls, `dout_drive` stays high until the first rising edge after reset. From that edge on it follows R1.
- R4: In fall-through mode (`fwft_mode`=1), when the output register is empty (`out_valid`=0) and `fifo_empty`=0, `pop` is 1 and the head word is loaded into `dout` at the next edge, which sets `out_valid`. Chip select and read enable have no effect on this.
- R5: A read is accepted only at an edge where `csel_n` and `ren_n` are both low and `csel_n` was also low at the previous edge. At the first edge with chip select active, a low `ren_n` neither pops nor changes `dout`.
- R6: `proto_err` is 1 for the one cycle after an edge at which `ren_n` was low and `csel_n` went low for the first time. Otherwise it is 0.
- R7: `rt_accept` is 1 exactly when `rt_req` is 1, `csel_n` is 0 and `rst_busy` is 0.
- R8: `dout` keeps its value across every edge at which no word is popped.
- R9: In standard mode (`fwft_mode`=0), an accepted read with `fifo_empty`=0 pops and loads the head word into `dout` at that edge. An accepted read with `fifo_empty`=1 does not pop.
- R10: In fall-through mode, an accepted read while `fifo_empty`=1 clears `out_valid` and leaves `dout` unchanged. An accepted read while `fifo_empty`=0 pops and loads the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_busy | input | 1 | High while a master or partial reset is in progress (synchronous) |
| fwft_mode | input | 1 | 1 selects first-word-fall-through, 0 selects standard mode |
| csel_n | input | 1 | Read chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| ren_n | input | 1 | Read enable, active low |
| rt_req | input | 1 | Retransmit request |
| fifo_empty | input | 1 | Storage holds no word |
| mem_data | input | W | Word at the head of the storage |
| dout | output | W | Registered output word |
| dout_drive | output | 1 | 1 when the output bus is driven, 0 for high impedance |
| out_valid | output | 1 | Fall-through mode: output register holds an unread word |
| pop | output | 1 | Take the head word out of storage at this edge |
| rt_accept | output | 1 | Retransmit request passed on |
| proto_err | output | 1 | Read enable was asserted in the first chip-select cycle |

## Verification
A corrupted chip-select history register shows in two ways. `dout_drive` is wrong in the cycle right after the edge that loaded it. The read gate opens or closes one cycle early, so a word is popped in the first chip-select cycle or a read is lost one cycle later. A wrong output-valid bit shows as a missing fall-through pop before the next edge, or as a second word overwriting an unread one. That changes `dout` at the following edge. A wrong hold path shows as a change of `dout` at an edge where `pop` was low, and it is visible one cycle later.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    // Chip-select history and error flag of the read port
    typedef struct packed {
        logic cs_seen;   // chip select was active at the previous edge
        logic drv;       // registered drive request
        logic err;       // protocol error flag
    } cs_state_t;

    function automatic logic first_cs_cycle(input logic cs_now, input logic cs_prev);
        return cs_now && !cs_prev;
    endfunction

endpackage

// File: rtl/rdp_cs_track.sv
module rdp_cs_track
    import rdp_pkg::*;
(
    input  logic clk,
    input  logic rst_busy,
    input  logic csel_n,
    input  logic oe_n,
    input  logic ren_n,
    output logic cs_armed,
    output logic dout_drive,
    output logic proto_err
);

    cs_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rst_busy) begin
            st_d.cs_seen = 1'b0;
            st_d.drv     = 1'b1;   // keep bus under OE control until first edge after reset
            st_d.err     = 1'b0;
        end else begin
            st_d.cs_seen = !csel_n;
            st_d.drv     = !csel_n;
            st_d.err     = first_cs_cycle(!csel_n, st_q.cs_seen) && !ren_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cs_armed   = st_q.cs_seen;
    assign dout_drive = !oe_n && (rst_busy || st_q.drv);
    assign proto_err  = st_q.err;

    AST_CS_HIGH_RELEASE: assert property (@(posedge clk) disable iff (rst_busy)
        csel_n |=> !dout_drive);                                          // R1
    AST_CS_LOW_DRIVE: assert property (@(posedge clk) disable iff (rst_busy)
        !csel_n |=> (dout_drive == !oe_n));                               // R1
    AST_PROTO_FLAG: assert property (@(posedge clk) disable iff (rst_busy)
        (!csel_n && $past(csel_n) && !ren_n) |=> proto_err);              // R6

endmodule

// File: rtl/rdp_data_stage.sv
module rdp_data_stage #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_busy,
    input  logic         fwft_mode,
    input  logic         rd_req,
    input  logic         fifo_empty,
    input  logic [W-1:0] mem_data,
    output logic [W-1:0] dout,
    output logic         out_valid,
    output logic         pop
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         valid;
    } dstate_t;

    dstate_t st_q, st_d;
    logic    pop_d;

    always_comb begin
        st_d  = st_q;
        pop_d = 1'b0;
        if (rst_busy) begin
            st_d.word  = '0;
            st_d.valid = 1'b0;
        end else if (fwft_mode) begin
            if (!st_q.valid) begin
                if (!fifo_empty) begin
                    pop_d      = 1'b1;
                    st_d.word  = mem_data;
                    st_d.valid = 1'b1;
                end
            end else if (rd_req) begin
                if (!fifo_empty) begin
                    pop_d     = 1'b1;
                    st_d.word = mem_data;
                end else begin
                    st_d.valid = 1'b0;
                end
            end
        end else begin
            st_d.valid = 1'b0;
            if (rd_req && !fifo_empty) begin
                pop_d     = 1'b1;
                st_d.word = mem_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout      = st_q.word;
    assign out_valid = st_q.valid;
    assign pop       = pop_d;

    AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (rst_busy)
        !pop |=> $stable(dout));                                          // R8
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst_busy)
        (fwft_mode && !out_valid && !fifo_empty) |=> out_valid);          // R4

endmodule

// File: rtl/rdport_out_ctrl.sv
module rdport_out_ctrl #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_busy,
    input  logic         fwft_mode,
    input  logic         csel_n,
    input  logic         oe_n,
    input  logic         ren_n,
    input  logic         rt_req,
    input  logic         fifo_empty,
    input  logic [W-1:0] mem_data,
    output logic [W-1:0] dout,
    output logic         dout_drive,
    output logic         out_valid,
    output logic         pop,
    output logic         rt_accept,
    output logic         proto_err
);

    logic cs_armed;
    logic rd_req;

    rdp_cs_track u_cs (
        .clk        (clk),
        .rst_busy   (rst_busy),
        .csel_n     (csel_n),
        .oe_n       (oe_n),
        .ren_n      (ren_n),
        .cs_armed   (cs_armed),
        .dout_drive (dout_drive),
        .proto_err  (proto_err)
    );

    assign rd_req = !csel_n && cs_armed && !ren_n;

    rdp_data_stage #(.W(W)) u_data (
        .clk        (clk),
        .rst_busy   (rst_busy),
        .fwft_mode  (fwft_mode),
        .rd_req     (rd_req),
        .fifo_empty (fifo_empty),
        .mem_data   (mem_data),
        .dout       (dout),
        .out_valid  (out_valid),
        .pop        (pop)
    );

    assign rt_accept = rt_req && !csel_n && !rst_busy;

    AST_FIRST_CS_NO_READ: assert property (@(posedge clk) disable iff (rst_busy)
        (!fwft_mode && !csel_n && $past(csel_n)) |-> !pop);               // R5
    AST_RESET_OE_ONLY: assert property (@(posedge clk)
        rst_busy |-> (dout_drive == !oe_n));                              // R2
    AST_RT_NEEDS_CS: assert property (@(posedge clk)
        rt_accept |-> !csel_n);                                           // R7

endmodule

// File: tb/rdport_out_ctrl_tb.sv
module rdport_out_ctrl_tb;

    localparam int PERIOD = 10;
    localparam int W      = 36;

    logic         clk = 1'b0;
    logic         rst_busy, fwft_mode, csel_n, oe_n, ren_n, rt_req;
    logic         fifo_empty;
    logic [W-1:0] mem_data, dout;
    logic         dout_drive, out_valid, pop, rt_accept, proto_err;

    logic [W-1:0] mem [16];
    int wp = 0;
    int rp = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    assign fifo_empty = (wp == rp);
    assign mem_data   = mem[rp % 16];

    always @(posedge clk) if (pop) rp <= rp + 1;

    rdport_out_ctrl #(.W(W)) u_dut (
        .clk(clk), .rst_busy(rst_busy), .fwft_mode(fwft_mode), .csel_n(csel_n),
        .oe_n(oe_n), .ren_n(ren_n), .rt_req(rt_req), .fifo_empty(fifo_empty),
        .mem_data(mem_data), .dout(dout), .dout_drive(dout_drive),
        .out_valid(out_valid), .pop(pop), .rt_accept(rt_accept), .proto_err(proto_err)
    );

    // {csel_n, oe_n, expected dout_drive after the edge}
    localparam logic [2:0] DRV_VEC [8] = '{
        3'b001, 3'b010, 3'b100, 3'b001, 3'b110, 3'b001, 3'b001, 3'b100
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [W-1:0] v);
        mem[wp % 16] = v;
        wp = wp + 1;
    endtask

    initial begin
        #(PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_busy = 1; fwft_mode = 0; csel_n = 1; oe_n = 0; ren_n = 1; rt_req = 0;
        #1;
        step(); step(); step();
        // R2: reset, OE alone controls drive
        chk("R2 drive oe low", dout_drive, 1);
        oe_n = 1; #1;
        chk("R2 drive oe high", dout_drive, 0);
        oe_n = 0; csel_n = 0; step();
        chk("R2 cs low in reset", dout_drive, 1);
        csel_n = 1; step();
        chk("R2 cs high in reset", dout_drive, 1);
        chk("R2 dout cleared", dout, 0);
        chk("R2 valid cleared", out_valid, 0);
        chk("R2 no pop", pop, 0);

        // R3: drive held until first edge after reset
        rst_busy = 0; #1;
        chk("R3 held after release", dout_drive, 1);
        step();
        chk("R3 released at first edge", dout_drive, 0);

        // R1: table walk
        for (int i = 0; i < 8; i++) begin
            csel_n = DRV_VEC[i][2];
            oe_n   = DRV_VEC[i][1];
            step();
            chk("R1 table", dout_drive, DRV_VEC[i][0]);
        end

        // R1: one-edge lag in both directions
        csel_n = 0; oe_n = 0; #1;
        chk("R1 no drive before edge", dout_drive, 0);
        step();
        chk("R1 drive after edge", dout_drive, 1);
        csel_n = 1; #1;
        chk("R1 still driven before edge", dout_drive, 1);
        step();
        chk("R1 released after edge", dout_drive, 0);

        // R4: fall-through with chip select inactive
        fwft_mode = 1;
        push(36'h0AAAA0001);
        push(36'h0BBBB0002);
        #1;
        chk("R4 pop while cs inactive", pop, 1);
        step();
        chk("R4 word fell through", dout, 36'h0AAAA0001);
        chk("R4 valid set", out_valid, 1);
        chk("R4 bus undriven", dout_drive, 0);
        ren_n = 0; step();
        chk("R8 held without cs", dout, 36'h0AAAA0001);
        chk("R8 valid kept", out_valid, 1);

        // R5/R6: read enable in the first chip-select cycle
        csel_n = 0; #1;
        chk("R5 no pop first cs cycle", pop, 0);
        step();
        chk("R5 word not consumed", dout, 36'h0AAAA0001);
        chk("R6 protocol error", proto_err, 1);
        chk("R5 pop second cs cycle", pop, 1);
        step();
        chk("R5 next word read", dout, 36'h0BBBB0002);
        chk("R6 error cleared", proto_err, 0);
        step();
        chk("R10 valid cleared on empty read", out_valid, 0);
        chk("R10 dout held", dout, 36'h0BBBB0002);
        ren_n = 1;

        // R9: standard mode
        fwft_mode = 0;
        push(36'h0CCCC0003);
        push(36'h0DDDD0004);
        #1;
        chk("R8 no pop without ren", pop, 0);
        step();
        chk("R8 dout held without ren", dout, 36'h0BBBB0002);
        ren_n = 0; step();
        chk("R9 first read", dout, 36'h0CCCC0003);
        step();
        chk("R9 second read", dout, 36'h0DDDD0004);
        chk("R9 no pop when empty", pop, 0);
        step();
        chk("R8 dout held on empty read", dout, 36'h0DDDD0004);
        ren_n = 1;

        // R7: retransmit gating
        csel_n = 1; rt_req = 1; #1;
        chk("R7 refused with cs high", rt_accept, 0);
        csel_n = 0; #1;
        chk("R7 accepted with cs low", rt_accept, 1);
        rt_req = 0; #1;
        chk("R7 idle without request", rt_accept, 0);
        step();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule